// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block turns one asynchronous serial line into characters. Each character arrives framed by a low start bit and a high stop bit, with its data bits sent least significant bit first. The line is first passed through a synchroniser. It is then oversampled by an externally supplied tick, and every bit is judged at the middle of its period. Completed characters are pushed into a small receive queue. Each queue entry carries the data byte, an optional ninth bit and a framing-error flag. A ready flag tells the consumer that at least one character is waiting, and every read strobe removes the oldest one.

For multi-drop links, a filter can be switched on that keeps only characters whose ninth bit is set. A node uses this to listen for address characters and ignore traffic meant for other nodes. Once it has been addressed, it turns the filter off and takes in everything. When a further character completes while the queue is full, a sticky overrun flag is set. That flag blocks any further intake until the receiver enable is dropped.

Top module: `uart_addr_rx`

## Requirements
- R1: A frame is a low start bit, then data bits least significant first, then a stop bit. The line is synchronised through two flops and sampled at 16 ticks of `os_tick` per bit, taking each value at the mid-bit sample. In 8-bit mode the received byte appears on `rx_data`.
- R2: With `nine_bit_en`=1, a ninth bit is received after data bit 7 and is presented on `rx_bit9`. With `nine_bit_en`=0, a character's `rx_bit9` is 0.
- R3: The receiver works only while `port_en` and `rx_en` are both 1. Otherwise no frame is taken in and `rx_idle` is 1 from the following cycle.
- R4: `rx_ready` rises in the cycle after a character enters the queue, and stays 1 while any entry is unread.
- R5: The queue holds `BUF_DEPTH` (default 2) characters in arrival order. `rx_data`, `rx_bit9` and `rx_frame_err` show the oldest entry. A `buf_rd` pulse removes that entry, and `rx_ready` falls once the last entry is removed.
- R6: If an admitted character completes while the queue is full, `rx_overrun` becomes 1. That character is discarded and the stored entries are unchanged.
- R7: `rx_overrun` stays 1 until `rx_en` is 0, and it is 0 in the cycle after `rx_en` has been 0.
- R8: While `rx_overrun` is 1, no character enters the queue, even if there is room.
- R9: With `addr_det_en`=1 and `nine_bit_en`=1, only characters whose ninth bit is 1 enter the queue. The others raise no ready.
- R10: With `addr_det_en`=0, every completed character enters the queue. `addr_det_en`=1 in 8-bit mode also filters nothing.
- R11: A start bit that is high again at its mid-point sample is dropped, and the receiver returns to idle without storing anything.
- R12: A stop bit sampled low stores that character with `rx_frame_err`=1. A new start is recognised only on a high-to-low transition of the line.
- R13: `rx_idle` is 0 from the detection of a start edge until the stop-bit sample, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Receiver enable; low clears overrun |
| nine_bit_en | input | 1 | Receive a ninth data bit |
| addr_det_en | input | 1 | Keep only characters whose ninth bit is set |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_line | input | 1 | Serial input line |
| buf_rd | input | 1 | Read strobe; removes the oldest entry |
| rx_data | output | 8 | Data byte of the oldest entry |
| rx_bit9 | output | 1 | Ninth bit of the oldest entry |
| rx_frame_err | output | 1 | Framing error of the oldest entry |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_idle | output | 1 | No frame in progress |
| rx_ready | output | 1 | At least one character unread |

## Verification
The bench uses the default parameters: 16 ticks per bit, 8 data bits, a two-entry queue and two synchroniser stages. The tick is driven every second clock, so one bit lasts 32 clocks. With a queue only two entries deep, overrun is reached with a third unread character. That makes the sticky flag, its blocking of later characters and its release through the receiver enable cheap to reach, both in directed cases and in the random frames. The ninth-bit path and the filter are exercised with both settings of the mode inputs.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   // bits needed to hold values 0 .. n-1 (at least one)
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rx_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
module rx_framer
   import uart_rx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned DATA_BITS  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic                 nine,
   input  logic                 tick,
   input  logic                 line,
   output logic                 idle,
   output logic                 done,
   output logic [DATA_BITS-1:0] frm_data,
   output logic                 frm_b9,
   output logic                 frm_ferr
);

   localparam int unsigned MAXB = DATA_BITS + 1;
   localparam int unsigned CW   = cnt_bits(OVERSAMPLE);
   localparam int unsigned BW   = cnt_bits(MAXB + 1);
   localparam logic [CW-1:0] MID_LAST = CW'(OVERSAMPLE / 2 - 1);
   localparam logic [CW-1:0] BIT_LAST = CW'(OVERSAMPLE - 1);

   rx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [BW-1:0]    bidx;
   logic [BW-1:0]    last_idx;
   logic [MAXB-1:0]  shreg;
   logic             prev_line;

   assign last_idx = nine ? BW'(DATA_BITS) : BW'(DATA_BITS - 1);
   assign idle     = (state == RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         bidx      <= '0;
         shreg     <= '0;
         prev_line <= 1'b1;
         done      <= 1'b0;
         frm_data  <= '0;
         frm_b9    <= 1'b0;
         frm_ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            prev_line <= 1'b1;
         end else if (tick) begin
            prev_line <= line;
            unique case (state)
               RX_IDLE: begin
                  if (prev_line && !line) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID_LAST) begin
                     cnt   <= '0;
                     bidx  <= '0;
                     state <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == BIT_LAST) begin
                     cnt         <= '0;
                     shreg[bidx] <= line;
                     if (bidx == last_idx) state <= RX_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == BIT_LAST) begin
                     cnt      <= '0;
                     state    <= RX_IDLE;
                     done     <= 1'b1;
                     frm_ferr <= ~line;
                     frm_data <= shreg[DATA_BITS-1:0];
                     frm_b9   <= nine & shreg[DATA_BITS];
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
   import uart_rx_pkg::*;
#(
   parameter int unsigned WIDTH = 10,
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);

   localparam int unsigned PW = cnt_bits(DEPTH);
   localparam int unsigned NW = cnt_bits(DEPTH + 1);
   localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [NW-1:0]    fill;

   generate
      if (DEPTH < 2) begin : g_bad
         $error("rx_buffer needs a depth of at least two");
      end
   endgenerate

   assign empty = (fill == '0);
   assign full  = (fill == NW'(DEPTH));
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push) begin
            mem[wr_ptr] <= wdata;
            wr_ptr      <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
         end
         if (pop) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
         if (push && !pop)      fill <= fill + 1'b1;
         else if (pop && !push) fill <= fill - 1'b1;
      end
   end

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
   import uart_rx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned BUF_DEPTH   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ADDR_FILTER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 port_en,
   input  logic                 rx_en,
   input  logic                 nine_bit_en,
   input  logic                 addr_det_en,
   input  logic                 os_tick,
   input  logic                 rx_line,
   input  logic                 buf_rd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_bit9,
   output logic                 rx_frame_err,
   output logic                 rx_overrun,
   output logic                 rx_idle,
   output logic                 rx_ready
);

   localparam int unsigned ENTRY_W = DATA_BITS + 2;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_BITS < 5) begin : g_bad_db
         $error("DATA_BITS must be at least 5");
      end
   endgenerate

   logic                 line_s;
   logic                 active;
   logic                 frm_done, frm_b9, frm_ferr;
   logic [DATA_BITS-1:0] frm_data;
   logic                 keep_w, push_w, pop_w;
   logic                 buf_empty, buf_full;
   logic                 ovr_q;
   logic [ENTRY_W-1:0]   head;

   assign active = port_en & rx_en;

   rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (line_s)
   );

   rx_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) i_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .nine     (nine_bit_en),
      .tick     (os_tick),
      .line     (line_s),
      .idle     (rx_idle),
      .done     (frm_done),
      .frm_data (frm_data),
      .frm_b9   (frm_b9),
      .frm_ferr (frm_ferr)
   );

   generate
      if (ADDR_FILTER) begin : g_filter
         assign keep_w = ~(addr_det_en & nine_bit_en) | frm_b9;
      end else begin : g_nofilter
         assign keep_w = 1'b1;
      end
   endgenerate

   assign push_w = frm_done & keep_w & ~buf_full & ~ovr_q;
   assign pop_w  = buf_rd & ~buf_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ovr_q <= 1'b0;
      else if (!rx_en)                        ovr_q <= 1'b0;
      else if (frm_done && keep_w && buf_full) ovr_q <= 1'b1;
   end

   rx_buffer #(.WIDTH(ENTRY_W), .DEPTH(BUF_DEPTH)) i_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_w),
      .wdata ({frm_ferr, frm_b9, frm_data}),
      .pop   (pop_w),
      .rdata (head),
      .empty (buf_empty),
      .full  (buf_full)
   );

   assign rx_data      = head[DATA_BITS-1:0];
   assign rx_bit9      = head[DATA_BITS];
   assign rx_frame_err = head[DATA_BITS+1];
   assign rx_overrun   = ovr_q;
   assign rx_ready     = ~buf_empty;

endmodule

// File: rtl/rx_checker.sv
module rx_checker (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic rx_en,
   input logic nine_bit_en,
   input logic addr_det_en,
   input logic rx_idle,
   input logic rx_ready,
   input logic rx_overrun,
   input logic frm_done,
   input logic frm_b9,
   input logic push,
   input logic buf_full
);

   assert_b9_zero_8bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && !nine_bit_en |-> !frm_b9);

   assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en && rx_en) |=> rx_idle);

   assert_ready_after_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> rx_ready);

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> !push);

   assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun && rx_en |=> rx_overrun);

   assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_overrun);

   assert_ovr_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> !push);

   assert_addr_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push && addr_det_en && nine_bit_en |-> frm_b9);

   assert_all_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && !addr_det_en && !rx_overrun && !buf_full |-> push);

endmodule

bind uart_addr_rx rx_checker i_rx_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .port_en     (port_en),
   .rx_en       (rx_en),
   .nine_bit_en (nine_bit_en),
   .addr_det_en (addr_det_en),
   .rx_idle     (rx_idle),
   .rx_ready    (rx_ready),
   .rx_overrun  (rx_overrun),
   .frm_done    (frm_done),
   .frm_b9      (frm_b9),
   .push        (push_w),
   .buf_full    (buf_full)
);

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;

   localparam int BIT_CLKS = 32;   // 16 ticks, one tick every second clock
   localparam int DEPTH    = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_en = 1'b1, rx_en = 1'b1, nine_bit_en = 1'b0, addr_det_en = 1'b0;
   logic       os_tick = 1'b0, rx_line = 1'b1, buf_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9, rx_frame_err, rx_overrun, rx_idle, rx_ready;

   int n_checks = 0;
   int n_fail   = 0;
   bit done_flag = 0;

   logic [9:0] q[$];   // {ferr, b9, data}
   bit ovr_m = 0;

   always #10 clk = ~clk;

   uart_addr_rx i_uart_addr_rx (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
      .nine_bit_en(nine_bit_en), .addr_det_en(addr_det_en), .os_tick(os_tick),
      .rx_line(rx_line), .buf_rd(buf_rd), .rx_data(rx_data), .rx_bit9(rx_bit9),
      .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .rx_idle(rx_idle),
      .rx_ready(rx_ready)
   );

   initial forever begin
      @(negedge clk);
      os_tick = ~os_tick;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit admitted(input logic [8:0] v, input bit nine, input bit addr);
      return !(addr && nine) || v[8];
   endfunction

   function automatic logic [9:0] make_entry(input logic [8:0] v, input bit nine, input bit stop_ok);
      return {~stop_ok, nine & v[8], v[7:0]};
   endfunction

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] v, input bit stop_ok);
      int nb;
      bit live;
      nb   = nine_bit_en ? 9 : 8;
      live = port_en && rx_en;
      rx_line = 1'b0;
      wait_clks(BIT_CLKS);
      for (int i = 0; i < nb; i++) begin
         rx_line = v[i];
         wait_clks(BIT_CLKS / 2);
         if (i == 2) chk(live ? "R13" : "R3", "rx_idle mid-frame", rx_idle, !live);
         wait_clks(BIT_CLKS / 2);
      end
      rx_line = stop_ok;
      wait_clks(BIT_CLKS);
      rx_line = 1'b1;
      wait_clks(8);
      if (live && admitted(v, nine_bit_en, addr_det_en)) begin
         if (ovr_m) ;
         else if (q.size() == DEPTH) ovr_m = 1;
         else q.push_back(make_entry(v, nine_bit_en, stop_ok));
      end
   endtask

   task automatic check_state(input string req);
      chk(req, "rx_ready", rx_ready, q.size() != 0);
      chk(req, "rx_overrun", rx_overrun, ovr_m);
   endtask

   task automatic read_one(input string req);
      logic [9:0] e;
      e = q.pop_front();
      chk("R4", "rx_ready before read", rx_ready, 1'b1);
      chk(req, "rx_data", rx_data, e[7:0]);
      chk(req, "rx_bit9", rx_bit9, e[8]);
      chk(req, "rx_frame_err", rx_frame_err, e[9]);
      buf_rd = 1'b1;
      @(negedge clk);
      buf_rd = 1'b0;
      @(negedge clk);
      chk("R5", "rx_ready after read", rx_ready, q.size() != 0);
   endtask

   task automatic clear_ovr();
      rx_en = 1'b0;
      wait_clks(3);
      chk("R7", "overrun cleared by rx_en low", rx_overrun, 1'b0);
      rx_en = 1'b1;
      ovr_m = 0;
      wait_clks(2);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_up();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      wait_clks(5);
      chk("R4", "ready after reset", rx_ready, 1'b0);
      chk("R13", "idle after reset", rx_idle, 1'b1);
      chk("R7", "overrun after reset", rx_overrun, 1'b0);
      rst_n = 1'b1;
      wait_clks(10);

      // R1: plain 8-bit frame
      send(9'h0A5, 1); check_state("R1"); read_one("R1");
      send(9'h03C, 1); read_one("R1");

      // R2: ninth bit in both modes
      nine_bit_en = 1; send(9'h13C, 1); read_one("R2");
      send(9'h0C3, 1); read_one("R2");
      nine_bit_en = 0; send(9'h1FF, 1); read_one("R2");

      // R5: order of two entries
      send(9'h011, 1); send(9'h022, 1); check_state("R5");
      read_one("R5"); read_one("R5");

      // R6 / R8 / R7: overrun
      send(9'h0A1, 1); send(9'h0A2, 1); send(9'h0A3, 1);
      check_state("R6");
      read_one("R6"); read_one("R6");
      send(9'h0A4, 1); check_state("R8");
      clear_ovr();
      send(9'h0A5, 1); check_state("R7"); read_one("R7");

      // R9 / R10: address filter
      nine_bit_en = 1; addr_det_en = 1;
      send(9'h055, 1); check_state("R9");
      send(9'h1AA, 1); check_state("R9"); read_one("R9");
      addr_det_en = 0; send(9'h033, 1); check_state("R10"); read_one("R10");
      nine_bit_en = 0; addr_det_en = 1; send(9'h044, 1); check_state("R10"); read_one("R10");
      addr_det_en = 0;

      // R11: short start glitch
      rx_line = 1'b0; wait_clks(8); rx_line = 1'b1; wait_clks(64);
      chk("R11", "idle after glitch", rx_idle, 1'b1);
      check_state("R11");

      // R12: framing error
      send(9'h05A, 0); read_one("R12");
      send(9'h06B, 1); read_one("R12");

      // R3: disabled receiver
      port_en = 0; send(9'h077, 1);
      chk("R3", "idle when port disabled", rx_idle, 1'b1); check_state("R3");
      port_en = 1; rx_en = 0; send(9'h088, 1); check_state("R3");
      rx_en = 1; wait_clks(4);

      // random frames
      for (int n = 0; n < 60; n++) begin
         logic [8:0] v;
         v = 9'($urandom);
         nine_bit_en = $urandom % 2;
         addr_det_en = ($urandom % 4) == 0;
         send(v, ($urandom % 8) != 0);
         check_state(addr_det_en ? "R9" : "R10");
         if (ovr_m && ($urandom % 2)) clear_ovr();
         for (int r = 0; r < int'($urandom % 3); r++)
            if (q.size() != 0) read_one("R5");
      end
      while (q.size() != 0) read_one("R5");
      check_state("R5");

      done_flag = 1;
      finish_up();
   end

endmodule